// File: doc/BRIEF.md
# Multiplexed Boot ROM Port Controller

This block connects a simple host request (read or write, one byte or a 32-bit longword) to an external parallel ROM or flash and to an optional 8-bit external register. All of these share one 8-bit address/data bus, which two external address latches also watch. Every byte access runs the same three phases. The first address phase carries the low address bits and the read/write strobes. The second address phase carries the middle address bits. The data phase asserts the single active-low chip enable and moves the data. Two dedicated address pins carry the bits the 8-bit bus cannot: the low pin carries bit 16, then bit 17, then bit 0. The other pin is high in the first address phase, low in the second, and bit 1 in the data phase, so its edges strobe the external latches.

A longword request runs four byte accesses at consecutive byte addresses and assembles the read bytes into one 32-bit word. The data phase length comes from a small timing field, which suits slow parts. The requester sees a busy flag while a transfer runs and a one-cycle done pulse when the transfer ends.

The sequencer has four states: IDLE, ADR_LO (first address phase), ADR_HI (second address phase) and DATA. Its transitions are:
- IDLE goes to ADR_LO when a request is accepted.
- ADR_LO always goes to ADR_HI.
- ADR_HI always goes to DATA.
- DATA stays in DATA until its wait count expires.
- From DATA, the sequencer goes to ADR_LO if more bytes of a longword remain, and to IDLE otherwise.

Top module: `romport_ctrl`

## Requirements
- R1: After reset the block is idle: `req_busy`=0, `req_done`=0, `rom_ce_n`=1, `bus_oe`=0 and `req_rdata`=0.
- R2: A request (`req_valid`=1) is taken only in a cycle where `req_busy`=0. A request raised while busy is ignored: the running transfer continues unchanged and no further transfer follows it.
- R3: In the first cycle after acceptance (and before each later byte of a longword), the first address phase drives the bus with `bus_oe`=1 and `rom_ce_n`=1. Bits 7:2 carry address bits 7:2. Bit 1 is the active-low read strobe (0 for a read). Bit 0 is the active-low write strobe (0 for a write). `rom_a0` carries address bit 16 and `rom_a1`=1.
- R4: The second address phase lasts exactly one cycle and follows the first. It drives address bits 15:8 on the bus with `bus_oe`=1, sets `rom_a0` to address bit 17 and `rom_a1`=0, and keeps `rom_ce_n`=1.
- R5: The data phase follows the second address phase. It holds `rom_ce_n`=0, `rom_a0` = address bit 0 and `rom_a1` = address bit 1, and lasts `cfg_wait` cycles; a value of 0 gives one cycle.
- R6: In a write data phase the bus drives the write byte (`bus_oe`=1). In a read data phase the bus floats (`bus_oe`=0), and `bus_in` is sampled on the clock edge that ends the last data cycle only.
- R7: A longword access (`req_long`=1) performs four byte accesses at addresses base+0 to base+3, wrapping modulo 2^18. Byte i uses `req_wdata`/`req_rdata` bits 8i+7:8i.
- R8: A byte read returns the byte zero-extended in `req_rdata`. A byte write uses `req_wdata` bits 7:0.
- R9: `req_done` is high for exactly one cycle, the cycle after the last data cycle, and `req_busy` is low in that cycle. `req_rdata` is valid from that cycle until the next request is accepted. A new request can be accepted in the done cycle.
- R10: While idle, the bus floats (`bus_oe`=0) and `rom_ce_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 32-bit longword, 0 = single byte |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 32 | Write data |
| cfg_wait | input | WAIT_W | Data phase length in cycles (0 means 1) |
| req_busy | output | 1 | Transfer in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Assembled read data |
| rom_ce_n | output | 1 | Active-low chip enable for ROM or external register |
| rom_a0 | output | 1 | Address bit 16 / 17 / 0 by phase |
| rom_a1 | output | 1 | Latch strobe in address phases, address bit 1 in the data phase |
| bus_out | output | 8 | Shared address/data bus, outgoing value |
| bus_oe | output | 1 | Bus drive enable |
| bus_in | input | 8 | Shared bus, incoming value |

## Verification
The completion pulse of one transfer and the acceptance of the next request can fall in the same cycle. To provoke this, the bench raises a new request in the very cycle it observes `req_done`, chaining a longword write straight into a longword read. It then checks that the new transfer's first address phase appears on the next cycle, with no idle cycle between. The bench also varies `bus_in` during the early data cycles of a read, so that sampling too soon would show up as a wrong assembled byte.

// File: rtl/romport_pkg.sv
package romport_pkg;
    localparam int ROM_AW = 18;
    localparam int BUS_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADR_LO = 2'd1,
        ST_ADR_HI = 2'd2,
        ST_DATA   = 2'd3
    } romport_state_t;
endpackage

// File: rtl/romport_seq.sv
module romport_seq
    import romport_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int WAIT_W = 4,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = BUS_W * LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_long,
    input  logic [ROM_AW-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [WAIT_W-1:0]    cfg_wait,
    output romport_state_t       state_q,
    output logic                 accept,
    output logic [ROM_AW-1:0]    cur_addr,
    output logic                 cur_write,
    output logic [BUS_W-1:0]     cur_wbyte,
    output logic [IDX_W-1:0]     byte_idx,
    output logic                 data_last,
    output logic                 final_byte
);
    romport_state_t          state_d;
    logic [ROM_AW-1:0]       base_q;
    logic                    long_q;
    logic [WORD_W-1:0]       wdata_q;
    logic [WAIT_W-1:0]       wait_q;
    logic [WAIT_W-1:0]       cnt_q;
    logic [IDX_W-1:0]        idx_q;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign data_last  = (state_q == ST_DATA) && (cnt_q == '0);
    assign final_byte = !long_q || (idx_q == IDX_W'(LANES - 1));
    assign cur_addr   = base_q + ROM_AW'(idx_q);
    assign cur_wbyte  = wdata_q[BUS_W*int'(idx_q) +: BUS_W];
    assign byte_idx   = idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ADR_LO;
            ST_ADR_LO: state_d = ST_ADR_HI;
            ST_ADR_HI: state_d = ST_DATA;
            ST_DATA:   if (cnt_q == '0) state_d = final_byte ? ST_IDLE : ST_ADR_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            cur_write <= 1'b0;
            long_q    <= 1'b0;
            wdata_q   <= '0;
            wait_q    <= WAIT_W'(1);
            cnt_q     <= '0;
            idx_q     <= '0;
        end else begin
            if (accept) begin
                base_q    <= req_addr;
                cur_write <= req_write;
                long_q    <= req_long;
                wdata_q   <= req_wdata;
                wait_q    <= (cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;
                idx_q     <= '0;
            end
            if (state_q == ST_ADR_HI) begin
                cnt_q <= wait_q - WAIT_W'(1);
            end else if (state_q == ST_DATA && cnt_q != '0) begin
                cnt_q <= cnt_q - WAIT_W'(1);
            end
            if (data_last && !final_byte) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // R5: the data phase counter never exceeds the programmed length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cnt_q < wait_q));

    // R7: a byte access never advances past its only lane
    p_byte_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_q && state_q != ST_IDLE) |-> (idx_q == '0));
endmodule

// File: rtl/romport_mux.sv
module romport_mux
    import romport_pkg::*;
(
    input  romport_state_t       state_q,
    input  logic [ROM_AW-1:0]    cur_addr,
    input  logic                 cur_write,
    input  logic [BUS_W-1:0]     cur_wbyte,
    output logic [BUS_W-1:0]     bus_out,
    output logic                 bus_oe,
    output logic                 rom_a0,
    output logic                 rom_a1,
    output logic                 rom_ce_n
);
    always_comb begin
        bus_out  = '0;
        bus_oe   = 1'b0;
        rom_a0   = 1'b0;
        rom_a1   = 1'b0;
        rom_ce_n = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADR_LO: begin
                bus_out = {cur_addr[7:2], cur_write, !cur_write};
                bus_oe  = 1'b1;
                rom_a0  = cur_addr[16];
                rom_a1  = 1'b1;
            end
            ST_ADR_HI: begin
                bus_out = cur_addr[15:8];
                bus_oe  = 1'b1;
                rom_a0  = cur_addr[17];
            end
            ST_DATA: begin
                bus_out  = cur_write ? cur_wbyte : '0;
                bus_oe   = cur_write;
                rom_a0   = cur_addr[0];
                rom_a1   = cur_addr[1];
                rom_ce_n = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/romport_pack.sv
module romport_pack
    import romport_pkg::*;
#(
    parameter  int LANES  = 4,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = BUS_W * LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 capture,
    input  logic                 finish,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [BUS_W-1:0]     bus_in,
    output logic [WORD_W-1:0]    rdata,
    output logic                 done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                rdata <= '0;
            end else if (capture) begin
                rdata[BUS_W*int'(byte_idx) +: BUS_W] <= bus_in;
            end
        end
    end

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/romport_ctrl.sv
module romport_ctrl
    import romport_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int WAIT_W = 4,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = BUS_W * LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_long,
    input  logic [ROM_AW-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [WAIT_W-1:0]    cfg_wait,
    output logic                 req_busy,
    output logic                 req_done,
    output logic [WORD_W-1:0]    req_rdata,
    output logic                 rom_ce_n,
    output logic                 rom_a0,
    output logic                 rom_a1,
    output logic [BUS_W-1:0]     bus_out,
    output logic                 bus_oe,
    input  logic [BUS_W-1:0]     bus_in
);
    romport_state_t     state_q;
    logic               accept;
    logic [ROM_AW-1:0]  cur_addr;
    logic               cur_write;
    logic [BUS_W-1:0]   cur_wbyte;
    logic [IDX_W-1:0]   byte_idx;
    logic               data_last;
    logic               final_byte;

    assign req_busy = (state_q != ST_IDLE);

    romport_seq #(.LANES(LANES), .WAIT_W(WAIT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_long   (req_long),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cfg_wait   (cfg_wait),
        .state_q    (state_q),
        .accept     (accept),
        .cur_addr   (cur_addr),
        .cur_write  (cur_write),
        .cur_wbyte  (cur_wbyte),
        .byte_idx   (byte_idx),
        .data_last  (data_last),
        .final_byte (final_byte)
    );

    romport_mux u_mux (
        .state_q   (state_q),
        .cur_addr  (cur_addr),
        .cur_write (cur_write),
        .cur_wbyte (cur_wbyte),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .rom_a0    (rom_a0),
        .rom_a1    (rom_a1),
        .rom_ce_n  (rom_ce_n)
    );

    romport_pack #(.LANES(LANES)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (data_last && !cur_write),
        .finish   (data_last && final_byte),
        .byte_idx (byte_idx),
        .bus_in   (bus_in),
        .rdata    (req_rdata),
        .done     (req_done)
    );

    // R2: an idle request starts a transfer on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_busy) |=> req_busy);

    // R3: the first address phase is followed by the second
    p_adr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && rom_a1 && rom_ce_n) |=> (req_busy && !rom_a1 && rom_ce_n && bus_oe));

    // R4: the second address phase is followed by chip enable
    p_ce_after_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && !rom_a1 && rom_ce_n) |=> !rom_ce_n);

    // R6: a selected read never drives the bus
    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !cur_write) |-> !bus_oe);

    // R10: the bus floats and the device is deselected while idle
    p_idle_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!bus_oe && rom_ce_n));
endmodule

// File: tb/sim_romport_ctrl.sv
module sim_romport_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_long;
    logic [17:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  cfg_wait;
    logic        req_busy, req_done;
    logic [31:0] req_rdata;
    logic        rom_ce_n, rom_a0, rom_a1, bus_oe;
    logic [7:0]  bus_out, bus_in;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] last_rd = '0;

    always #4 clk = ~clk;

    romport_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .req_busy(req_busy), .req_done(req_done),
        .req_rdata(req_rdata), .rom_ce_n(rom_ce_n), .rom_a0(rom_a0),
        .rom_a1(rom_a1), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Starts at a negedge with the request applied there; ends at the negedge of the done cycle.
    task automatic run_access(input bit wr, input bit lng, input logic [17:0] addr,
                              input logic [31:0] wd, input logic [3:0] wt, input bit poke);
        int          n  = (wt == 0) ? 1 : int'(wt);
        int          nb = lng ? 4 : 1;
        logic [31:0] exp_rd = '0;
        req_valid = 1'b1; req_write = wr; req_long = lng;
        req_addr = addr; req_wdata = wd; cfg_wait = wt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            logic [17:0] a = addr + 18'(b);
            logic [7:0]  db;
            if (b != 0) @(negedge clk);
            chk("R3 adr_lo bus", {24'b0, bus_out}, {24'b0, a[7:2], wr, !wr});
            chk("R3 adr_lo pins", {28'b0, bus_oe, rom_ce_n, rom_a1, rom_a0}, {28'b0, 1'b1, 1'b1, 1'b1, a[16]});
            chk("R2 busy in transfer", {31'b0, req_busy}, 32'd1);
            if (poke && b == 0) begin
                req_valid = 1'b1; req_addr = 18'h3FFFF; req_write = !wr;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R4 adr_hi bus", {24'b0, bus_out}, {24'b0, a[15:8]});
            chk("R4 adr_hi pins", {28'b0, bus_oe, rom_ce_n, rom_a1, rom_a0}, {28'b0, 1'b1, 1'b1, 1'b0, a[17]});
            db = rom_byte(a);
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                chk("R5 data pins", {29'b0, rom_ce_n, rom_a1, rom_a0}, {29'b0, 1'b0, a[1], a[0]});
                chk("R6 data drive", {31'b0, bus_oe}, {31'b0, wr});
                if (wr) chk("R7 write byte", {24'b0, bus_out}, {24'b0, wd[8*b +: 8]});
                bus_in = (j == n - 1) ? db : ~db;
            end
            if (!wr) exp_rd[8*b +: 8] = db;
        end
        @(negedge clk);
        bus_in = 8'hEE;
        chk("R9 done pulse", {30'b0, req_done, req_busy}, {30'b0, 1'b1, 1'b0});
        chk("R9 rdata", req_rdata, exp_rd);
        chk("R10 done idle pins", {30'b0, bus_oe, rom_ce_n}, {30'b0, 1'b0, 1'b1});
        last_rd = exp_rd;
    endtask

    task automatic idle_check(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R2 idle no transfer", {30'b0, req_busy, req_done}, 32'd0);
            chk("R10 idle pins", {30'b0, bus_oe, rom_ce_n}, {30'b0, 1'b0, 1'b1});
            chk("R9 rdata held", req_rdata, last_rd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired act=0 exp=1");
        summary();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_long = 1'b0;
        req_addr = '0; req_wdata = '0; cfg_wait = 4'd1; bus_in = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R1 reset status", {30'b0, req_busy, req_done}, 32'd0);
        chk("R1 reset pins", {30'b0, bus_oe, rom_ce_n}, {30'b0, 1'b0, 1'b1});
        chk("R1 reset rdata", req_rdata, 32'd0);
        rst_n = 1'b1;
        idle_check(1);
        // R8 byte read, two-cycle data phase
        run_access(1'b0, 1'b0, 18'h2A5C3, 32'h0, 4'd2, 1'b0);
        idle_check(2);
        // R8 byte write
        run_access(1'b1, 1'b0, 18'h1F00D, 32'hDEADBE77, 4'd1, 1'b0);
        idle_check(1);
        // R7 longword read wrapping at the top of the space
        run_access(1'b0, 1'b1, 18'h3FFFE, 32'h0, 4'd3, 1'b0);
        idle_check(1);
        // R5 zero wait, then R9 accept in the done cycle with the longest wait
        run_access(1'b1, 1'b1, 18'h04321, 32'hC0FFEE12, 4'd0, 1'b0);
        run_access(1'b0, 1'b1, 18'h12340, 32'h0, 4'd15, 1'b0);
        idle_check(1);
        // R2 request raised while busy is ignored
        run_access(1'b0, 1'b0, 18'h00A4B, 32'h0, 4'd4, 1'b1);
        idle_check(3);
        summary();
    end
endmodule